// File: doc/BRIEF.md
# Multi-Mode Asynchronous Serial Channel

A full-duplex asynchronous serial transmitter and receiver. A 3-bit format selector picks one of five frame layouts: 8 data bits, 7 data bits with a generated parity bit, 9 data bits, 8 data bits with a generated parity bit, or 8 data bits followed by a wake-up bit. Software-level inputs choose odd or even parity, turn parity checking on, and select one or two stop bits on the transmit side.

Bit timing comes from an external tick that runs at 16 times the bit rate. A write strobe loads a transmit word while the transmitter is idle. The receiver samples each bit at its middle and hands back a 9-bit receive word with a one-cycle done pulse. It also reports sticky parity-error and framing-error flags, which a clear strobe resets, and a one-cycle error interrupt request.

Top module: `async_serial_chan`

## Requirements
- R1: A frame on `txd` is a 0 start bit, then the payload bits LSB first, then one stop bit of 1 (two when `stop2` is 1). Each bit lasts 16 `os_tick` pulses, and `txd` is 1 whenever the transmitter is idle.
- R2: `fmt_sel` encodings: 001 = 8 data bits; 011 = 7 data bits + parity; 100 = 9 data bits; 111 = 8 data bits + parity; 101 = 8 data bits + wake-up bit (`tx_data[8]`). Unlisted codes behave as 001. In 8-bit payload modes `rx_buf[8]` reads 0.
- R3: The generated parity bit is the XOR of the data bits when `par_odd` is 0, and its inverse when `par_odd` is 1. It covers bits 6..0 in mode 011 and bits 7..0 in mode 111.
- R4: The received parity bit is returned in `rx_buf[7]` in mode 011 and in `rx_buf[8]` in mode 111.
- R5: A received parity bit is checked only when `par_chk_en` is 1 and the mode is 011 or 111. In every other case no parity error is raised.
- R6: A wrong received parity bit sets `par_err` and pulses `err_irq` in the same cycle as `rx_done`.
- R7: In mode 101, a frame whose ninth bit is 0 is dropped: no `rx_done`, no buffer update, no flag. A frame whose ninth bit is 1 is delivered.
- R8: A start bit that is no longer low at its middle is treated as a glitch. No frame is received, and the receiver then accepts the next real frame.
- R9: A first stop bit sampled as 0 sets `frm_err` and pulses `err_irq` together with `rx_done`, and the word is still delivered.
- R10: `par_err` and `frm_err` stay set until an `err_clr` pulse clears them.
- R11: `tx_busy` rises the cycle after an accepted write and stays high for the whole frame. Writes while busy are ignored.
- R12: After reset, `txd` is 1, `tx_busy`, `rx_done`, `par_err`, `frm_err` and `err_irq` are 0, and `rx_buf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversampling tick, 16 per bit |
| fmt_sel | input | 3 | Frame format selector |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| par_chk_en | input | 1 | Enable receive parity checking |
| stop2 | input | 1 | Transmit two stop bits |
| tx_wr | input | 1 | Transmit write strobe |
| tx_data | input | 9 | Transmit word |
| err_clr | input | 1 | Clear the error flags |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_busy | output | 1 | Transmitter sending a frame |
| rx_buf | output | 9 | Last received word |
| rx_done | output | 1 | One-cycle pulse: new word in rx_buf |
| par_err | output | 1 | Sticky parity error |
| frm_err | output | 1 | Sticky framing error |
| err_irq | output | 1 | One-cycle error interrupt request |

## Verification
The bound checker runs on every cycle. It checks that the idle line stays high, that the transmitter only goes busy after a write, that done is a single pulse, that each error interrupt comes with a done pulse, that each new error flag comes with an interrupt, that the flags hold until cleared, and that no parity error appears when checking is off or the mode has no parity. Some behaviour only the bench scenarios can show: the exact bit layout and parity values of each format, the placement of the parity bit in the receive word, and the frame length for one versus two stop bits. The same goes for dropping wake-up frames, rejecting a glitch on the start bit, and detecting a real parity or stop-bit fault. The bench covers these with looped-back and hand-built frames.

// File: rtl/async_serial_chan.sv
module async_serial_chan #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic [2:0] fmt_sel,
  input  logic       par_odd,
  input  logic       par_chk_en,
  input  logic       stop2,
  input  logic       tx_wr,
  input  logic [8:0] tx_data,
  input  logic       err_clr,
  input  logic       rxd,
  output logic       txd,
  output logic       tx_busy,
  output logic [8:0] rx_buf,
  output logic       rx_done,
  output logic       par_err,
  output logic       frm_err,
  output logic       err_irq
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [2:0] F_P7 = 3'b011, F_B9 = 3'b100, F_WK = 3'b101, F_P8 = 3'b111;

  function automatic logic par_bit(input logic [7:0] d, input logic odd);
    return odd ? ~^d : ^d;
  endfunction

  logic nine;
  assign nine = (fmt_sel == F_B9) || (fmt_sel == F_WK) || (fmt_sel == F_P8);

  // transmit
  logic [8:0]    tx_pay;
  logic [11:0]   tx_sh;
  logic [3:0]    tx_left;
  logic [CW-1:0] tx_cnt;

  always_comb begin
    case (fmt_sel)
      F_P7:       tx_pay = {1'b0, par_bit({1'b0, tx_data[6:0]}, par_odd), tx_data[6:0]};
      F_P8:       tx_pay = {par_bit(tx_data[7:0], par_odd), tx_data[7:0]};
      F_B9, F_WK: tx_pay = tx_data;
      default:    tx_pay = {1'b0, tx_data[7:0]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_left <= '0;
      tx_cnt  <= '0;
    end else if (!tx_busy && tx_wr) begin
      tx_busy <= 1'b1;
      tx_cnt  <= '0;
      tx_sh   <= nine ? {2'b11, tx_pay, 1'b0} : {3'b111, tx_pay[7:0], 1'b0};
      tx_left <= 4'd1 + (nine ? 4'd9 : 4'd8) + (stop2 ? 4'd2 : 4'd1);
    end else if (tx_busy && os_tick) begin
      if (tx_cnt == LAST) begin
        tx_cnt <= '0;
        if (tx_left == 4'd1) begin
          tx_busy <= 1'b0;
        end else begin
          tx_sh   <= {1'b1, tx_sh[11:1]};
          tx_left <= tx_left - 4'd1;
        end
      end else begin
        tx_cnt <= tx_cnt + CW'(1);
      end
    end
  end

  assign txd = tx_busy ? tx_sh[0] : 1'b1;

  // receive
  typedef enum logic [1:0] {R_IDLE, R_START, R_BITS} rx_st_t;
  rx_st_t        rx_st;
  logic          rx_s1, rx_s2;
  logic [CW-1:0] rx_cnt;
  logic [3:0]    rx_idx;
  logic [8:0]    rx_sh, rx_word;
  logic          par_bad;

  assign rx_word = nine ? rx_sh : {1'b0, rx_sh[8:1]};
  assign par_bad = par_chk_en &&
    (((fmt_sel == F_P7) && (rx_word[7] != par_bit({1'b0, rx_word[6:0]}, par_odd))) ||
     ((fmt_sel == F_P8) && (rx_word[8] != par_bit(rx_word[7:0], par_odd))));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1   <= 1'b1;
      rx_s2   <= 1'b1;
      rx_st   <= R_IDLE;
      rx_cnt  <= '0;
      rx_idx  <= '0;
      rx_sh   <= '0;
      rx_buf  <= '0;
      rx_done <= 1'b0;
      err_irq <= 1'b0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
    end else begin
      rx_s1   <= rxd;
      rx_s2   <= rx_s1;
      rx_done <= 1'b0;
      err_irq <= 1'b0;
      if (err_clr) begin
        par_err <= 1'b0;
        frm_err <= 1'b0;
      end
      if (os_tick) begin
        case (rx_st)
          R_IDLE: if (!rx_s2) begin
            rx_st  <= R_START;
            rx_cnt <= '0;
          end
          R_START: if (rx_cnt == MID) begin
            rx_st  <= rx_s2 ? R_IDLE : R_BITS;
            rx_cnt <= '0;
            rx_idx <= '0;
          end else begin
            rx_cnt <= rx_cnt + CW'(1);
          end
          default: if (rx_cnt == LAST) begin
            rx_cnt <= '0;
            if (rx_idx == (nine ? 4'd9 : 4'd8)) begin
              rx_st <= R_IDLE;
              if (!((fmt_sel == F_WK) && !rx_word[8])) begin
                rx_buf  <= rx_word;
                rx_done <= 1'b1;
                if (par_bad) par_err <= 1'b1;
                if (!rx_s2)  frm_err <= 1'b1;
                err_irq <= par_bad || !rx_s2;
              end
            end else begin
              rx_sh  <= {rx_s2, rx_sh[8:1]};
              rx_idx <= rx_idx + 4'd1;
            end
          end else begin
            rx_cnt <= rx_cnt + CW'(1);
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/async_serial_chan_chk.sv
module async_serial_chan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] fmt_sel,
  input logic       par_chk_en,
  input logic       tx_wr,
  input logic       err_clr,
  input logic       txd,
  input logic       tx_busy,
  input logic       rx_done,
  input logic       par_err,
  input logic       frm_err,
  input logic       err_irq
);
  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  // R11
  busy_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_wr));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);
  // R6
  irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> rx_done);
  // R6
  perr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_err) |-> err_irq);
  // R9
  ferr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_err) |-> err_irq);
  // R10
  perr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err && !err_clr |=> par_err);
  // R10
  ferr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err && !err_clr |=> frm_err);
  // R5
  no_par_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && (!par_chk_en || !(fmt_sel == 3'b011 || fmt_sel == 3'b111))) |-> !$rose(par_err));
endmodule

bind async_serial_chan async_serial_chan_chk u_chk (.*);

// File: tb/async_serial_chan_tb.sv
`timescale 1ns/1ps
module async_serial_chan_tb;
  logic clk = 0, rst_n = 0, os_tick = 0;
  logic [2:0] fmt_sel = 3'b001;
  logic par_odd = 0, par_chk_en = 0, stop2 = 0, tx_wr = 0, err_clr = 0;
  logic [8:0] tx_data = '0;
  logic loop_en = 1, inj_line = 1;
  logic rxd, txd, tx_busy, rx_done, par_err, frm_err, err_irq;
  logic [8:0] rx_buf;
  int checks = 0, errors = 0, busy_ticks = 0, done_cnt = 0;
  logic [11:0] exp_q[$];
  string tag_q[$];

  assign rxd = loop_en ? txd : inj_line;

  async_serial_chan u_dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .fmt_sel(fmt_sel), .par_odd(par_odd),
    .par_chk_en(par_chk_en), .stop2(stop2), .tx_wr(tx_wr), .tx_data(tx_data),
    .err_clr(err_clr), .rxd(rxd), .txd(txd), .tx_busy(tx_busy), .rx_buf(rx_buf),
    .rx_done(rx_done), .par_err(par_err), .frm_err(frm_err), .err_irq(err_irq));

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] expect_word(input logic [2:0] m, input logic [8:0] w, input logic odd);
    logic p;
    case (m)
      3'b011: begin p = odd ^ (^w[6:0]); return {1'b0, p, w[6:0]}; end
      3'b111: begin p = odd ^ (^w[7:0]); return {p, w[7:0]}; end
      3'b100, 3'b101: return w;
      default: return {1'b0, w[7:0]};
    endcase
  endfunction

  // tick every 4 clocks; count ticks seen while busy
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div = (div + 1) % 4;
      os_tick = (div == 0);
      if (os_tick && tx_busy) busy_ticks++;
    end
  end

  // monitor: pop and compare {irq, frm, par, buf}
  always @(negedge clk) begin
    if (rst_n && rx_done) begin
      done_cnt++;
      if (exp_q.size() == 0) begin
        check(0, "R7 unexpected frame", {23'd0, rx_buf}, 0);
      end else begin
        logic [11:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rx_buf == e[8:0], {t, " rx_buf"}, {23'd0, rx_buf}, {23'd0, e[8:0]});
        check(par_err == e[9], {t, " par_err"}, {31'd0, par_err}, {31'd0, e[9]});
        check(frm_err == e[10], {t, " frm_err"}, {31'd0, frm_err}, {31'd0, e[10]});
        check(err_irq == e[11], {t, " err_irq"}, {31'd0, err_irq}, {31'd0, e[11]});
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_exp(input logic [11:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic send(input logic [8:0] w, input bit deliver, input string t);
    while (tx_busy) @(negedge clk);
    if (deliver) push_exp({3'b000, expect_word(fmt_sel, w, par_odd)}, t);
    busy_ticks = 0;
    tx_data = w;
    tx_wr = 1;
    @(negedge clk);
    tx_wr = 0;
  endtask

  task automatic finish_frame();
    while (tx_busy) @(negedge clk);
    idle(80);
  endtask

  task automatic inject(input logic [11:0] bits, input int nb, input int last_ticks);
    loop_en = 0;
    for (int i = 0; i < nb; i++) begin
      inj_line = bits[i];
      idle(((i == nb - 1) ? last_ticks : 16) * 4);
    end
    inj_line = 1;
    idle(160);
    loop_en = 1;
  endtask

  task automatic clear_flags();
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c0;
    idle(5);
    rst_n = 1;
    idle(2);
    // R12 reset state
    check(txd == 1 && tx_busy == 0, "R12 tx idle", {30'd0, txd, tx_busy}, 32'h2);
    check(rx_buf == 0 && !rx_done && !par_err && !frm_err && !err_irq, "R12 rx idle",
          {18'd0, rx_buf, rx_done, par_err, frm_err, err_irq}, 0);

    // R1 R2: 8-bit, one stop
    fmt_sel = 3'b001; stop2 = 0;
    send(9'h0A5, 1, "R2 mode001 A5");
    finish_frame();
    check(busy_ticks == 160, "R1 10-bit frame length", busy_ticks, 160);
    send(9'h13C, 1, "R2 mode001 3C");
    finish_frame();

    // R1 R2: 9-bit, two stops
    fmt_sel = 3'b100; stop2 = 1;
    send(9'h1A5, 1, "R2 mode100 1A5");
    finish_frame();
    check(busy_ticks == 192, "R1 12-bit frame length", busy_ticks, 192);
    stop2 = 0;

    // R3 R4: 7+parity
    fmt_sel = 3'b011; par_chk_en = 1; par_odd = 0;
    send(9'h055, 1, "R3 R4 even p7 55");
    finish_frame();
    send(9'h007, 1, "R3 R4 even p7 07");
    finish_frame();
    par_odd = 1;
    send(9'h007, 1, "R3 R4 odd p7 07");
    finish_frame();

    // R3 R4: 8+parity
    fmt_sel = 3'b111; par_odd = 0;
    send(9'h0FE, 1, "R3 R4 even p8 FE");
    finish_frame();
    par_odd = 1;
    send(9'h0FE, 1, "R3 R4 odd p8 FE");
    finish_frame();
    par_odd = 0;

    // R7 wake-up
    fmt_sel = 3'b101;
    c0 = done_cnt;
    send(9'h042, 0, "R7 wake 0");
    finish_frame();
    check(done_cnt == c0, "R7 ninth bit 0 dropped", done_cnt - c0, 0);
    send(9'h142, 1, "R7 wake 1");
    finish_frame();
    check(done_cnt == c0 + 1, "R7 ninth bit 1 delivered", done_cnt - c0, 1);

    // R6 R10: wrong parity in mode 111, even: data 01 needs parity 1, sent 0
    fmt_sel = 3'b111; par_chk_en = 1;
    push_exp({3'b101, 9'h001}, "R6 bad parity");
    inject({1'b1, 1'b0, 8'h01, 1'b0}, 11, 16);
    idle(200);
    check(par_err == 1, "R10 par_err sticky", {31'd0, par_err}, 1);
    clear_flags();
    check(par_err == 0, "R10 par_err cleared", {31'd0, par_err}, 0);

    // R5: same bad frame with checking off
    par_chk_en = 0;
    push_exp({3'b000, 9'h001}, "R5 check disabled");
    inject({1'b1, 1'b0, 8'h01, 1'b0}, 11, 16);
    // R5: non-parity mode with checking on
    fmt_sel = 3'b001; par_chk_en = 1;
    push_exp({3'b000, 9'h080}, "R5 mode001 no check");
    inject({1'b1, 8'h80, 1'b0}, 10, 16);

    // R9 R10: stop bit low, held 10 ticks
    push_exp({3'b110, 9'h05A}, "R9 framing error");
    inject({1'b0, 8'h5A, 1'b0}, 10, 10);
    check(frm_err == 1, "R10 frm_err sticky", {31'd0, frm_err}, 1);
    clear_flags();
    check(frm_err == 0, "R10 frm_err cleared", {31'd0, frm_err}, 0);

    // R8 glitch
    c0 = done_cnt;
    loop_en = 0; inj_line = 0;
    idle(12);
    inj_line = 1;
    idle(160);
    loop_en = 1;
    check(done_cnt == c0, "R8 glitch rejected", done_cnt - c0, 0);
    send(9'h0C3, 1, "R8 frame after glitch");
    finish_frame();

    // R11 busy and ignored write
    c0 = done_cnt;
    send(9'h011, 1, "R11 first word");
    check(tx_busy == 1, "R11 busy after write", {31'd0, tx_busy}, 1);
    idle(20);
    tx_data = 9'h022; tx_wr = 1;
    @(negedge clk);
    tx_wr = 0;
    finish_frame();
    idle(200);
    check(done_cnt == c0 + 1, "R11 write while busy ignored", done_cnt - c0, 1);

    check(exp_q.size() == 0, "R1 all frames received", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule